// File: doc/BRIEF.md
# Processor Control Pin Interrupt Front End

This block sits between eight asynchronous control pins of a processor and the core's interrupt and run-control logic. Every pin is brought into the clock domain through a synchroniser. The block keeps a record of the last level it accepted for each pin. A pin produces an action only in the cycle when its synchronised level differs from that record. The action depends on the pin. It can set or clear a bit in a small pending-interrupt vector, raise a one-cycle reset request, halt the core or wake it, or start and stop the time base.

The pending vector has four bits: bit 0 external interrupt, bit 1 system-management interrupt, bit 2 soft reset, bit 3 machine check. A combined request output is high whenever any pending bit is set. The machine-check bit is set on a falling edge of its pin. The pin cannot clear it, so the core clears it through an acknowledge input.

Top module: `pin_irq_ctrl`

## Requirements
- R1: A pin whose synchronised level equals its recorded level causes no action. Holding any pin at a steady level changes no output, and the one-cycle outputs stay low.
- R2: The external, system-management and soft-reset pins are level sensitive. A high level sets pending bit 0, 1 or 2 respectively, and a low level clears the same bit.
- R3: A falling edge of the machine-check pin sets pending bit 3. A rising edge of that pin leaves bit 3 unchanged.
- R4: A one-cycle high on `mchk_ack_i` clears pending bit 3. If a falling edge of the machine-check pin takes effect in the same cycle, the bit is set instead.
- R5: `tb_run_o` is high while the accepted level of the time-base enable pin is high, and low while it is low.
- R6: A rising edge of the hard-reset pin makes `core_rst_req_o` high for exactly one cycle.
- R7: A rising edge of the checkstop pin drives `halt_o` high. `halt_o` then stays high whatever the other pins do, until `rst_n` is asserted.
- R8: The halt pin drives `halt_o` high while its accepted level is high. Its accepted low level clears that halt.
- R9: `irq_req_o` is high exactly when the pending vector is nonzero. Clearing one bit leaves the request high while any other bit remains set.
- R10: While `rst_n` is low, the recorded levels, the synchroniser, the pending vector and all outputs are zero.
- R11: A pin change driven between two clock edges shows at the outputs after the third rising edge that follows it: two edges for the synchroniser and one for the action register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_irq_i | input | 1 | External interrupt pin, level |
| smi_irq_i | input | 1 | System-management interrupt pin, level |
| soft_rst_i | input | 1 | Soft-reset interrupt pin, level |
| mchk_i | input | 1 | Machine-check pin, falling-edge sensitive |
| tb_enable_i | input | 1 | Time-base enable pin |
| hard_rst_i | input | 1 | Hard-reset request pin |
| chk_stop_i | input | 1 | Checkstop pin, halts until reset |
| halt_i | input | 1 | Halt pin, halt while high |
| mchk_ack_i | input | 1 | Core acknowledge that clears pending bit 3 |
| pending_o | output | 4 | Pending vector: bit 0 external, bit 1 system-management, bit 2 soft reset, bit 3 machine check |
| irq_req_o | output | 1 | Combined hard-interrupt request |
| tb_run_o | output | 1 | Time base running |
| core_rst_req_o | output | 1 | One-cycle reset request to the core |
| halt_o | output | 1 | Core halt request |

## Verification
A corrupted recorded level shows up as one of two faults. Either an action fires with no pin activity, or a real edge is lost. Both are visible on `pending_o`, `halt_o` or `core_rst_req_o` in the cycle after the fault. The worst case is a machine-check edge that is lost, or one that fires when it should not. The pin cannot undo either fault, so bit 3 stays wrong until the next acknowledge. A wrong combined request shows at once as `irq_req_o` disagreeing with `pending_o` in the same cycle. A checkstop halt that releases before reset is visible on `halt_o` in the next cycle.

// File: rtl/pin_irq_ctrl.sv
module pin_irq_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ext_irq_i,
  input  logic       smi_irq_i,
  input  logic       soft_rst_i,
  input  logic       mchk_i,
  input  logic       tb_enable_i,
  input  logic       hard_rst_i,
  input  logic       chk_stop_i,
  input  logic       halt_i,
  input  logic       mchk_ack_i,
  output logic [3:0] pending_o,
  output logic       irq_req_o,
  output logic       tb_run_o,
  output logic       core_rst_req_o,
  output logic       halt_o
);
  localparam int NPIN = 8;
  localparam int P_EXT = 0, P_SMI = 1, P_SRST = 2, P_MCK = 3;
  localparam int P_TB = 4, P_HRST = 5, P_CSTP = 6, P_HALT = 7;

  logic [NPIN-1:0] pins_raw;
  logic [SYNC_STAGES-1:0][NPIN-1:0] sync_q;
  logic [NPIN-1:0] lvl, rec_q, chg, rise, fall;
  logic [3:0] pend_q, pend_d;
  logic       req_q, tb_q, rstp_q, stop_q, hold_q;

  assign pins_raw = {halt_i, chk_stop_i, hard_rst_i, tb_enable_i,
                     mchk_i, soft_rst_i, smi_irq_i, ext_irq_i};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], pins_raw};

  assign lvl  = sync_q[SYNC_STAGES-1];
  assign chg  = lvl ^ rec_q;
  assign rise = chg & lvl;
  assign fall = chg & ~lvl;

  always_comb begin
    pend_d = pend_q;
    for (int i = P_EXT; i <= P_SRST; i++)
      if (chg[i]) pend_d[i] = lvl[i];
    if (mchk_ack_i)  pend_d[P_MCK] = 1'b0;
    if (fall[P_MCK]) pend_d[P_MCK] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rec_q  <= '0;
      pend_q <= '0;
      req_q  <= 1'b0;
      tb_q   <= 1'b0;
      rstp_q <= 1'b0;
      stop_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      rec_q  <= lvl;
      pend_q <= pend_d;
      req_q  <= |pend_d;
      if (chg[P_TB])   tb_q   <= lvl[P_TB];
      rstp_q <= rise[P_HRST];
      if (rise[P_CSTP]) stop_q <= 1'b1;
      if (chg[P_HALT]) hold_q <= lvl[P_HALT];
    end

  assign pending_o      = pend_q;
  assign irq_req_o      = req_q;
  assign tb_run_o       = tb_q;
  assign core_rst_req_o = rstp_q;
  assign halt_o         = stop_q | hold_q;

  assert_steady_no_action_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (chg == '0 && !mchk_ack_i) |=> ($stable(pend_q) && !core_rst_req_o && $stable(halt_o)));
  assert_mchk_edge_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pending_o[P_MCK]) |-> $past(rec_q[P_MCK] && !lvl[P_MCK]));
  assert_ack_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mchk_ack_i && !fall[P_MCK]) |=> !pending_o[P_MCK]);
  assert_rst_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst_req_o |=> !core_rst_req_o);
  assert_stop_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_q |=> halt_o);
  assert_req_vector_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req_o == (pending_o != 4'd0));
endmodule

// File: tb/test_pin_irq_ctrl.sv
module test_pin_irq_ctrl;
  logic clk = 1'b0, rst_n = 1'b0, ack = 1'b0;
  logic [7:0] pins = '0;
  logic [3:0] pending;
  logic irq_req, tb_run, rst_req, halt;
  int n_chk = 0, n_fail = 0;

  logic [7:0] m_rec;
  logic [3:0] m_pend;
  logic m_tb, m_stop, m_hold, m_rstp;

  always #5 clk = ~clk;

  pin_irq_ctrl i_pin_irq_ctrl (
    .clk(clk), .rst_n(rst_n),
    .ext_irq_i(pins[0]), .smi_irq_i(pins[1]), .soft_rst_i(pins[2]),
    .mchk_i(pins[3]), .tb_enable_i(pins[4]), .hard_rst_i(pins[5]),
    .chk_stop_i(pins[6]), .halt_i(pins[7]), .mchk_ack_i(ack),
    .pending_o(pending), .irq_req_o(irq_req), .tb_run_o(tb_run),
    .core_rst_req_o(rst_req), .halt_o(halt));

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_rec = '0; m_pend = '0; m_tb = 0; m_stop = 0; m_hold = 0; m_rstp = 0;
  endtask

  task automatic model_step(input logic [7:0] nw);
    logic [7:0] chg;
    chg = nw ^ m_rec;
    m_pend[2:0] = nw[2:0];
    if (chg[3] && !nw[3]) m_pend[3] = 1'b1;
    m_tb = nw[4];
    m_rstp = chg[5] & nw[5];
    if (chg[6] && nw[6]) m_stop = 1'b1;
    m_hold = nw[7];
    m_rec = nw;
  endtask

  task automatic check_all(input string req);
    check(req, {4'd0, pending}, {4'd0, m_pend});
    check({req, "/R9"}, {7'd0, irq_req}, {7'd0, m_pend != 4'd0});
    check({req, "/R5"}, {7'd0, tb_run}, {7'd0, m_tb});
    check({req, "/R6"}, {7'd0, rst_req}, {7'd0, m_rstp});
    check({req, "/R7R8"}, {7'd0, halt}, {7'd0, m_stop | m_hold});
  endtask

  task automatic step_pins(input logic [7:0] nw, input string req);
    pins = nw;
    repeat (3) @(negedge clk);
    model_step(nw);
    check_all(req);
  endtask

  task automatic pulse_ack();
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    m_pend[3] = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    model_reset();
    check_all("R10");
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] p;
    void'($urandom(32'h1a2b3c4d));
    model_reset();
    @(negedge clk);
    do_reset();

    // R11 latency: ext goes high, visible after third edge only
    pins = 8'h01;
    repeat (2) @(negedge clk);
    check("R11 early", {4'd0, pending}, 8'h00);
    @(negedge clk);
    model_step(8'h01);
    check_all("R11 R2 ext set");

    step_pins(8'h03, "R2 smi set");
    step_pins(8'h02, "R2 ext clear R9 still high");
    step_pins(8'h00, "R2 smi clear");
    step_pins(8'h04, "R2 sreset set");
    step_pins(8'h00, "R2 sreset clear");

    step_pins(8'h08, "R3 rising ignored");
    step_pins(8'h00, "R3 falling sets");
    pulse_ack();
    check("R4 ack clears", {4'd0, pending}, 8'h00);
    repeat (6) @(negedge clk);
    check("R1 steady low mchk no reset", {4'd0, pending}, 8'h00);

    // R4 same-cycle: falling edge effective together with ack
    step_pins(8'h08, "R3 rising again");
    pins = 8'h00;
    repeat (2) @(negedge clk);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    model_step(8'h00);
    check("R4 edge wins over ack", {4'd0, pending}, 8'h08);
    pulse_ack();
    check("R4 cleared after", {4'd0, pending}, 8'h00);

    step_pins(8'h10, "R5 tb on");
    step_pins(8'h00, "R5 tb off");

    step_pins(8'h20, "R6 pulse");
    @(negedge clk);
    m_rstp = 1'b0;
    check("R6 one cycle", {7'd0, rst_req}, 8'h00);
    repeat (4) @(negedge clk);
    check("R1 held hard reset", {7'd0, rst_req}, 8'h00);
    step_pins(8'h00, "R6 release");

    step_pins(8'h80, "R8 halt on");
    step_pins(8'h00, "R8 halt off");

    step_pins(8'h40, "R7 stop");
    step_pins(8'h00, "R7 sticky");
    step_pins(8'h80, "R7 halt pin");
    step_pins(8'h00, "R7 still stopped");
    do_reset();

    for (int k = 0; k < 300; k++) begin
      p = 8'($urandom);
      p[6] = 1'b0;
      if ($urandom % 4 == 0) pulse_ack();
      step_pins(p, "R1 R2 R3 random");
    end

    finish_run();
  end
endmodule